// File: doc/BRIEF.md
# Pin Bank Controller with Set/Clear Registers

This block sits between a group of chip pads and the on-chip peripherals that want to use them. Each pin is either handed to its peripheral, which then drives the pad's output value and output enable, or taken over by the controller, which drives the pad from its own registers. Every incoming pad level is synchronised and can be passed through a small glitch filter. The conditioned level goes back to the peripheral and can be read by software.

Software changes the control words without a read-modify-write. Each control word has a set address and a clear address, and a third address reads the stored word. A level change on any pin sets a sticky status bit. A read of the status word clears it. A single interrupt line is raised when any status bit is set and its enable bit is also set.

Top module: `pio_bank`

## Requirements
- R1: After reset the ownership, output-enable, output-data, filter-enable and interrupt-enable words read 0, the status word reads 0 and irq is low. With ownership 0, padOut equals perOut and padOe equals perOe.
- R2: A write to a word's set address (byte offset 0x10*k + 0x0) sets every bit written as 1 and leaves every bit written as 0 unchanged. The word index k is 0 for ownership, 1 for output enable, 2 for output data, 3 for filter enable and 4 for interrupt enable.
- R3: A write to a word's clear address (0x10*k + 0x4) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R4: A read of a word's read address (0x10*k + 0x8) returns the stored word, with read data valid in the APB access phase.
- R5: For each pin i where ownership bit i is 1, padOut[i] follows output-data bit i and padOe[i] follows output-enable bit i. Where ownership bit i is 0, padOut[i] follows perOut[i] and padOe[i] follows perOe[i].
- R6: With its filter bit at 0, a new pad level reaches perIn and the pin-level word (offset 0x50) two clock edges after it is applied.
- R7: With its filter bit at 1, a pin passes a new level only after two consecutive synchronised samples agree on it. A one-cycle pulse never reaches perIn, and a held level reaches perIn on the fourth edge.
- R8: A change of a conditioned level sets that pin's status bit one edge after the change shows on perIn. A read of the status word (offset 0x54) returns the bits and clears them.
- R9: irq is high exactly when some status bit is set and its interrupt-enable bit is 1. A masked pin still latches its status bit.
- R10: Writes to a read address leave the stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| apbSel | input | 1 | APB select |
| apbEnable | input | 1 | APB access phase |
| apbWrite | input | 1 | APB write (1) or read (0) |
| apbAddr | input | ADDR_W | APB byte address |
| apbWdata | input | DATA_W | APB write data |
| apbRdata | output | DATA_W | APB read data |
| perOut | input | NPIN | Output values from peripherals |
| perOe | input | NPIN | Output enables from peripherals |
| perIn | output | NPIN | Conditioned pad levels sent to peripherals |
| padIn | input | NPIN | Raw pad input levels |
| padOut | output | NPIN | Pad output values |
| padOe | output | NPIN | Pad output enables |
| irq | output | 1 | Combined interrupt |

## Verification
A register write takes effect on the edge that ends its access phase, so the read-back follows in the next transfer. The pad multiplexer is combinational, and the bench checks it one nanosecond after it drives peripheral values at a falling edge. Pad input levels are applied at a falling edge. An unfiltered pin is checked one nanosecond after the first and second rising edges. A filtered pin is checked after the third and fourth edges, and the status bit and irq one edge after the level shows up. A one-cycle pulse is watched for six edges to confirm that the filter rejects it.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int NUM_REGS   = 5;
  localparam int REG_STRIDE = 4;   // word slots per control word
  localparam int WORD_LEVEL = 20;  // byte offset 0x50
  localparam int WORD_STAT  = 21;  // byte offset 0x54

  typedef enum logic [2:0] {
    RD_NONE, RD_OWN, RD_OE, RD_DOUT, RD_FILT, RD_IEN, RD_LEVEL, RD_STAT
  } rdSel_e;

  typedef struct packed {
    logic [NUM_REGS-1:0] setEn;
    logic [NUM_REGS-1:0] clrEn;
    logic                statRdClr;
    rdSel_e              rdSel;
  } pioStrobe_t;

endpackage

// File: rtl/pio_regctl.sv
module pio_regctl
  import pio_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              apbSel,
  input  logic              apbEnable,
  input  logic              apbWrite,
  input  logic [ADDR_W-1:0] apbAddr,
  output pioStrobe_t        strobes
);

  localparam int WIDX = ADDR_W - 2;

  logic [WIDX-1:0] wordIdx;
  logic            aligned;
  logic            wrHit;
  logic            rdHit;

  assign wordIdx = apbAddr[ADDR_W-1:2];
  assign aligned = (apbAddr[1:0] == 2'b00);
  assign wrHit   = apbSel & apbEnable & apbWrite & aligned;
  assign rdHit   = apbSel & apbEnable & ~apbWrite & aligned;

  always_comb begin
    strobes       = '0;
    strobes.rdSel = RD_NONE;
    if (wrHit) begin
      for (int k = 0; k < NUM_REGS; k++) begin
        if (wordIdx == WIDX'(REG_STRIDE * k))     strobes.setEn[k] = 1'b1;
        if (wordIdx == WIDX'(REG_STRIDE * k + 1)) strobes.clrEn[k] = 1'b1;
      end
    end
    if (rdHit) begin
      for (int k = 0; k < NUM_REGS; k++) begin
        if (wordIdx == WIDX'(REG_STRIDE * k + 2)) strobes.rdSel = rdSel_e'(3'(k + 1));
      end
      if (wordIdx == WIDX'(WORD_LEVEL)) strobes.rdSel = RD_LEVEL;
      if (wordIdx == WIDX'(WORD_STAT)) begin
        strobes.rdSel     = RD_STAT;
        strobes.statRdClr = 1'b1;
      end
    end
  end

endmodule

// File: rtl/pio_pincond.sv
module pio_pincond (
  input  logic clk,
  input  logic rstN,
  input  logic padIn,
  input  logic filtEn,
  output logic condOut
);

  logic syncQ1, syncQ2, syncQ3, filtQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ1 <= 1'b0;
      syncQ2 <= 1'b0;
      syncQ3 <= 1'b0;
      filtQ  <= 1'b0;
    end else begin
      syncQ1 <= padIn;
      syncQ2 <= syncQ1;
      syncQ3 <= syncQ2;
      if (syncQ2 == syncQ3) filtQ <= syncQ2;
    end
  end

  assign condOut = filtEn ? filtQ : syncQ2;

  // a filtered level only moves to a value the sample chain has settled on
  AST_FILTER_AGREE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(filtQ) |-> (syncQ3 == filtQ)); // R7

endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
  import pio_pkg::*;
#(
  parameter int NPIN   = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  pioStrobe_t        strobes,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NPIN-1:0]   perOut,
  input  logic [NPIN-1:0]   perOe,
  output logic [NPIN-1:0]   perIn,
  input  logic [NPIN-1:0]   padIn,
  output logic [NPIN-1:0]   padOut,
  output logic [NPIN-1:0]   padOe,
  output logic              irq
);

  localparam int IDX_OWN  = 0;
  localparam int IDX_OE   = 1;
  localparam int IDX_DOUT = 2;
  localparam int IDX_FILT = 3;
  localparam int IDX_IEN  = 4;

  logic [NUM_REGS-1:0][NPIN-1:0] regQ;
  logic [NPIN-1:0] wBits;
  logic [NPIN-1:0] condIn, prevCond, changeHit, statusQ;
  logic [NPIN-1:0] ownQ, oeQ, doutQ, filtQ, ienQ;

  assign wBits = wdata[NPIN-1:0];
  assign ownQ  = regQ[IDX_OWN];
  assign oeQ   = regQ[IDX_OE];
  assign doutQ = regQ[IDX_DOUT];
  assign filtQ = regQ[IDX_FILT];
  assign ienQ  = regQ[IDX_IEN];

  // set/clear register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regQ <= '0;
    end else begin
      for (int k = 0; k < NUM_REGS; k++) begin
        if (strobes.setEn[k])      regQ[k] <= regQ[k] | wBits;
        else if (strobes.clrEn[k]) regQ[k] <= regQ[k] & ~wBits;
      end
    end
  end

  // ownership multiplexing
  assign padOut = (ownQ & doutQ) | (~ownQ & perOut);
  assign padOe  = (ownQ & oeQ)   | (~ownQ & perOe);

  // per-pin input conditioning
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    pio_pincond u_cond (
      .clk     (clk),
      .rstN    (rstN),
      .padIn   (padIn[i]),
      .filtEn  (filtQ[i]),
      .condOut (condIn[i])
    );
  end
  assign perIn = condIn;

  // change detection and sticky status
  assign changeHit = condIn ^ prevCond;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCond <= '0;
      statusQ  <= '0;
    end else begin
      prevCond <= condIn;
      statusQ  <= (strobes.statRdClr ? '0 : statusQ) | changeHit;
    end
  end

  assign irq = |(statusQ & ienQ);

  // read mux
  always_comb begin
    unique case (strobes.rdSel)
      RD_OWN:   rdata = DATA_W'(ownQ);
      RD_OE:    rdata = DATA_W'(oeQ);
      RD_DOUT:  rdata = DATA_W'(doutQ);
      RD_FILT:  rdata = DATA_W'(filtQ);
      RD_IEN:   rdata = DATA_W'(ienQ);
      RD_LEVEL: rdata = DATA_W'(condIn);
      RD_STAT:  rdata = DATA_W'(statusQ);
      default:  rdata = '0;
    endcase
  end

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_chk
    AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
      strobes.setEn[k] |=> (regQ[k] == ($past(regQ[k]) | $past(wBits)))); // R2
    AST_CLR_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
      strobes.clrEn[k] |=> (regQ[k] == ($past(regQ[k]) & ~$past(wBits)))); // R3
  end

  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.setEn == '0 && strobes.clrEn == '0) |=> $stable(regQ)); // R10

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.statRdClr |=> ((statusQ & $past(statusQ)) == $past(statusQ))); // R8

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (ienQ != '0 && statusQ != '0)); // R9

endmodule

// File: rtl/pio_bank.sv
module pio_bank
  import pio_pkg::*;
#(
  parameter int NPIN   = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              apbSel,
  input  logic              apbEnable,
  input  logic              apbWrite,
  input  logic [ADDR_W-1:0] apbAddr,
  input  logic [DATA_W-1:0] apbWdata,
  output logic [DATA_W-1:0] apbRdata,
  input  logic [NPIN-1:0]   perOut,
  input  logic [NPIN-1:0]   perOe,
  output logic [NPIN-1:0]   perIn,
  input  logic [NPIN-1:0]   padIn,
  output logic [NPIN-1:0]   padOut,
  output logic [NPIN-1:0]   padOe,
  output logic              irq
);

  pioStrobe_t strobes;

  pio_regctl #(.ADDR_W(ADDR_W)) u_ctl (
    .apbSel    (apbSel),
    .apbEnable (apbEnable),
    .apbWrite  (apbWrite),
    .apbAddr   (apbAddr),
    .strobes   (strobes)
  );

  pio_datapath #(.NPIN(NPIN), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wdata   (apbWdata),
    .rdata   (apbRdata),
    .perOut  (perOut),
    .perOe   (perOe),
    .perIn   (perIn),
    .padIn   (padIn),
    .padOut  (padOut),
    .padOe   (padOe),
    .irq     (irq)
  );

endmodule

// File: tb/pio_bank_test.sv
`timescale 1ns/1ps
module pio_bank_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        apbSel = 1'b0, apbEnable = 1'b0, apbWrite = 1'b0;
  logic [7:0]  apbAddr = '0;
  logic [31:0] apbWdata = '0;
  logic [31:0] apbRdata;
  logic [31:0] perOut = '0, perOe = '0, perIn, padIn = '0, padOut, padOe;
  logic        irq;

  int total = 0;
  int bad = 0;
  logic [31:0] model [5];

  always #2.5 clk = ~clk;

  pio_bank uut (
    .clk(clk), .rstN(rstN), .apbSel(apbSel), .apbEnable(apbEnable),
    .apbWrite(apbWrite), .apbAddr(apbAddr), .apbWdata(apbWdata),
    .apbRdata(apbRdata), .perOut(perOut), .perOe(perOe), .perIn(perIn),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .irq(irq)
  );

  function automatic logic [31:0] expMux(input logic [31:0] own, ctl, per);
    return (own & ctl) | (~own & per);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apbWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    apbSel = 1'b1; apbEnable = 1'b0; apbWrite = 1'b1; apbAddr = a; apbWdata = d;
    @(negedge clk);
    apbEnable = 1'b1;
    @(negedge clk);
    apbSel = 1'b0; apbEnable = 1'b0; apbWrite = 1'b0;
  endtask

  task automatic apbRd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    apbSel = 1'b1; apbEnable = 1'b0; apbWrite = 1'b0; apbAddr = a;
    @(negedge clk);
    apbEnable = 1'b1;
    #1 d = apbRdata;
    @(negedge clk);
    apbSel = 1'b0; apbEnable = 1'b0;
  endtask

  task automatic edgeSample;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL all watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd4711));
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // reset state
    for (int k = 0; k < 5; k++) begin
      model[k] = '0;
      apbRd(8'(16 * k + 8), rd);
      chk("R1 word reset", rd, 32'h0);
    end
    apbRd(8'h54, rd);
    chk("R1 status reset", rd, 32'h0);
    chk("R1 irq reset", {31'h0, irq}, 32'h0);
    @(negedge clk);
    perOut = $urandom(); perOe = $urandom();
    #1;
    chk("R1 padOut follows peripheral", padOut, perOut);
    chk("R1 padOe follows peripheral", padOe, perOe);

    // random set/clear traffic with read-back and mux checks
    for (int it = 0; it < 40; it++) begin
      int k;
      logic [31:0] d;
      bit doSet;
      k = $urandom_range(0, 4);
      d = $urandom();
      doSet = $urandom_range(0, 1) != 0;
      if (doSet) begin
        apbWr(8'(16 * k), d);
        model[k] = model[k] | d;
      end else begin
        apbWr(8'(16 * k + 4), d);
        model[k] = model[k] & ~d;
      end
      apbRd(8'(16 * k + 8), rd);
      chk(doSet ? "R2 set read-back" : "R3 clear read-back", rd, model[k]);
      if (it % 4 == 0) begin
        apbWr(8'(16 * k + 8), ~model[k]);
        apbRd(8'(16 * k + 8), rd);
        chk("R10 write to read address ignored", rd, model[k]);
      end
      @(negedge clk);
      perOut = $urandom(); perOe = $urandom();
      #1;
      chk("R5 padOut mux", padOut, expMux(model[0], model[2], perOut));
      chk("R5 padOe mux", padOe, expMux(model[0], model[1], perOe));
    end
    chk("R9 irq low with no change", {31'h0, irq}, 32'h0);

    // directed corner: full ownership with drivers on
    apbWr(8'h00, 32'hFFFF_FFFF); model[0] = 32'hFFFF_FFFF;
    apbWr(8'h10, 32'h0000_FFFF); model[1] = model[1] | 32'h0000_FFFF;
    @(negedge clk);
    perOe = 32'h0; #1;
    chk("R5 owned pins ignore perOe", padOe, model[1]);

    for (int k = 0; k < 5; k++) begin
      apbWr(8'(16 * k + 4), 32'hFFFF_FFFF);
      model[k] = '0;
    end
    apbRd(8'h54, rd);

    // unfiltered input path, status and irq on pin 3
    apbWr(8'h40, 32'h8);
    padIn[3] = 1'b1;               // applied at a falling edge
    edgeSample;
    chk("R6 unfiltered after one edge", {31'h0, perIn[3]}, 32'h0);
    edgeSample;
    chk("R6 unfiltered after two edges", {31'h0, perIn[3]}, 32'h1);
    chk("R8 status not yet set", {31'h0, irq}, 32'h0);
    edgeSample;
    chk("R9 irq raised by enabled pin", {31'h0, irq}, 32'h1);
    apbRd(8'h54, rd);
    chk("R8 status shows pin 3", rd, 32'h8);
    apbRd(8'h54, rd);
    chk("R8 status cleared by read", rd, 32'h0);
    chk("R9 irq drops after clear", {31'h0, irq}, 32'h0);

    // filtered input path on pin 5, interrupt masked
    apbWr(8'h30, 32'h20);
    padIn[5] = 1'b1;
    @(negedge clk) padIn[5] = 1'b0;
    for (int c = 0; c < 6; c++) begin
      edgeSample;
      chk("R7 one-cycle pulse rejected", {31'h0, perIn[5]}, 32'h0);
    end
    @(negedge clk) padIn[5] = 1'b1;
    edgeSample; edgeSample; edgeSample;
    chk("R7 held level not yet passed", {31'h0, perIn[5]}, 32'h0);
    edgeSample;
    chk("R7 held level passed on fourth edge", {31'h0, perIn[5]}, 32'h1);
    edgeSample;
    chk("R9 masked pin keeps irq low", {31'h0, irq}, 32'h0);
    apbRd(8'h54, rd);
    chk("R8 masked pin status latched", rd, 32'h20);
    apbRd(8'h50, rd);
    chk("R6 pin-level word", rd, 32'h28);
    apbRd(8'h38, rd);
    chk("R4 filter word read", rd, 32'h20);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule